// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing half of a small serial EEPROM. It watches a two-wire clock line and data line, oversampled in the system clock domain. It recognises bus START and STOP conditions and shifts bytes in and out most significant bit first. It drives the data line only through an active-low open-drain enable. A write carries a device address, a word pointer and any number of data bytes, which are collected in a page buffer. A STOP then starts a modelled programming cycle, and at the end of that cycle the buffered bytes land in an internal byte array. A read streams bytes from the current pointer until the master declines to acknowledge.

While the programming cycle runs, the slave gives no acknowledge at all. A master therefore polls the device address until it is acknowledged again. Setting the pointer with a write that carries no data and then issuing a read gives a random read. A read with no pointer byte continues from where the last access stopped.

The bus state machine has six states. IDLE waits for a START. RX shifts in eight bits. ACK pulls the data line low for the ninth pulse. TX shifts a byte out. TXACK samples the master's acknowledge. IGNORE stays silent. A START moves any state to RX with the address role. A STOP moves any state to IDLE. RX moves to ACK on an accepted byte and to IGNORE on a foreign address or while busy. ACK moves to TX after a read address and otherwise back to RX, with the byte role advancing from address to pointer to data. TX moves to TXACK after eight bits. TXACK moves back to TX on a master acknowledge and to IGNORE on a missing one.

Top module: `eeprom_2w_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START. From any state, it makes the slave begin receiving an address byte.
- R2: A rising data line while the clock line is high is a STOP. It returns the slave to idle, and a following START is served normally.
- R3: The slave samples received bits on the clock's rising edge, most significant bit first. It changes its data-line drive only while the clock line is low.
- R4: In the first byte after START, bits 7..1 are the device address and bit 0 is the direction (0 = write, 1 = read). When the address matches and no programming cycle is running, the slave pulls the data line low through the ninth clock pulse.
- R5: After a non-matching address the slave acknowledges nothing and changes no memory until the next START or STOP.
- R6: While a programming cycle runs, the slave acknowledges no byte and never pulls the data line.
- R7: In a write, the second byte sets the word pointer. Each later byte is acknowledged and buffered for the pointer's address, and the pointer then advances by one, wrapping modulo the array depth.
- R8: Of a write burst, only the last PAGE_BYTES data bytes are stored. Earlier ones are displaced oldest first.
- R9: A STOP after at least one complete data byte starts a programming cycle of PROG_CYCLES system clocks, and the bytes are in the array when it ends. A STOP after only the pointer byte starts no cycle. A START before the STOP discards the buffered bytes.
- R10: A read sends bytes starting at the pointer, which advances by one after each byte. A master acknowledge requests the next byte.
- R11: After a byte with no master acknowledge, the slave releases the data line and stays silent until START or STOP.
- R12: After reset the data line is released, every array byte is zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A bus edge reaches the state register three system clocks after it appears at the pins: two synchroniser stages, then the state update. The drive output follows that state without further delay. The bench's master model holds every clock phase for eight system clocks and reads acknowledges and data bits one clock after an edge, late in the high phase, so every sample lands well after the slave has settled. Committed bytes are checked only by reads that begin after the PROG_CYCLES window has passed, and the silence check covers that whole window clock by clock.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_IGNORE
    } bus_st_e;

    typedef enum logic [1:0] {
        B_ADDR, B_WORD, B_DATA
    } byte_role_e;
endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-1:0], raw};
    end

    assign lvl  = sh[STAGES-1];
    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ee2w_page_buf.sv
module ee2w_page_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [7:0]    push_data,
    input  logic [IW-1:0] sel,
    output logic [AW-1:0] out_addr,
    output logic [7:0]    out_data,
    output logic [IW:0]   count
);
    logic [AW-1:0] ent_addr [DEPTH];
    logic [7:0]    ent_data [DEPTH];
    logic [IW-1:0] wr_idx, oldest, rd_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_idx <= '0;
            count  <= '0;
        end else if (push) begin
            wr_idx <= wr_idx + 1'b1;
            if (count != (IW+1)'(DEPTH)) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            ent_addr[wr_idx] <= push_addr;
            ent_data[wr_idx] <= push_data;
        end
    end

    assign oldest   = (count == (IW+1)'(DEPTH)) ? wr_idx : '0;
    assign rd_idx   = oldest + sel;
    assign out_addr = ent_addr[rd_idx];
    assign out_data = ent_data[rd_idx];
endmodule

// File: rtl/ee2w_array.sv
module ee2w_array #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
    import ee2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_DEPTH   = 256,
    parameter int         PAGE_BYTES  = 16,
    parameter int         PROG_CYCLES = 1000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_low
);
    localparam int AW  = $clog2(MEM_DEPTH);
    localparam int IW  = $clog2(PAGE_BYTES);
    localparam int PCW = $clog2(PROG_CYCLES + 1);

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic bus_start, bus_stop;

    bus_st_e    st;
    byte_role_e role;
    logic [3:0]     bit_cnt;
    logic [7:0]     rx_sh, tx_sh, mem_rdata, buf_data;
    logic           rw, m_ack;
    logic [AW-1:0]  ptr, buf_addr;
    logic [IW:0]    buf_cnt;
    logic           prog_busy, prog_done, commit_go;
    logic [PCW-1:0] prog_cnt;
    logic           buf_push, buf_clr, mem_we, addr_hit;

    ee2w_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .raw(scl_i),
        .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
    ee2w_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .raw(sda_i),
        .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

    assign bus_start = sda_fall & scl_lvl & ~scl_rise;
    assign bus_stop  = sda_rise & scl_lvl & ~scl_rise;

    assign addr_hit  = (rx_sh[7:1] == DEV_ADDR) && !prog_busy;
    assign buf_push  = (st == S_RX) && scl_fall && (bit_cnt == 4'd8) && (role == B_DATA);
    assign prog_done = prog_busy && (prog_cnt == PCW'(PROG_CYCLES - 1));
    assign buf_clr   = (bus_start && !prog_busy) || prog_done;
    assign commit_go = bus_stop && (role == B_DATA) && (buf_cnt != '0) && !prog_busy;
    assign mem_we    = prog_busy && (32'(prog_cnt) < 32'(buf_cnt));

    ee2w_page_buf #(.DEPTH(PAGE_BYTES), .AW(AW)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(buf_push),
        .push_addr(ptr), .push_data(rx_sh), .sel(prog_cnt[IW-1:0]),
        .out_addr(buf_addr), .out_data(buf_data), .count(buf_cnt));

    ee2w_array #(.DEPTH(MEM_DEPTH)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(buf_addr),
        .wdata(buf_data), .raddr(ptr), .rdata(mem_rdata));

    // programming cycle timer: commits one buffered byte per clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_busy <= 1'b0;
            prog_cnt  <= '0;
        end else if (commit_go) begin
            prog_busy <= 1'b1;
            prog_cnt  <= '0;
        end else if (prog_busy) begin
            if (prog_done) prog_busy <= 1'b0;
            else           prog_cnt  <= prog_cnt + 1'b1;
        end
    end

    // bus state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            role    <= B_ADDR;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            rw      <= 1'b0;
            m_ack   <= 1'b0;
            ptr     <= '0;
        end else if (bus_start) begin
            st      <= S_RX;
            role    <= B_ADDR;
            bit_cnt <= '0;
        end else if (bus_stop) begin
            st      <= S_IDLE;
            role    <= B_ADDR;
        end else begin
            unique case (st)
                S_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        rx_sh   <= {rx_sh[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        unique case (role)
                            B_ADDR: begin
                                if (addr_hit) begin
                                    rw <= rx_sh[0];
                                    st <= S_ACK;
                                end else begin
                                    st <= S_IGNORE;
                                end
                            end
                            B_WORD: begin
                                ptr <= AW'(rx_sh);
                                st  <= S_ACK;
                            end
                            default: begin
                                ptr <= ptr + 1'b1;
                                st  <= S_ACK;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (role == B_ADDR && rw) begin
                            tx_sh <= mem_rdata;
                            ptr   <= ptr + 1'b1;
                            st    <= S_TX;
                        end else begin
                            role <= (role == B_ADDR) ? B_WORD : B_DATA;
                            st   <= S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            m_ack <= 1'b0;
                            st    <= S_TXACK;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= {tx_sh[6:0], 1'b1};
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            tx_sh   <= mem_rdata;
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            st      <= S_TX;
                        end else begin
                            st <= S_IGNORE;
                        end
                    end
                end
                S_IDLE, S_IGNORE: ;
            endcase
        end
    end

    // open-drain output enable
    always_comb begin
        sda_pull_low = 1'b0;
        unique case (st)
            S_ACK:   sda_pull_low = 1'b1;
            S_TX:    sda_pull_low = ~tx_sh[7];
            default: sda_pull_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/ee2w_checks.sv
module ee2w_checks
    import ee2w_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    localparam int CW = $clog2(PAGE_BYTES) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          bus_start,
    input logic          bus_stop,
    input logic          drive,
    input logic          prog_busy,
    input bus_st_e       st,
    input logic [3:0]    bit_cnt,
    input logic          buf_push,
    input logic [CW-1:0] buf_cnt
);
    p_start_enters_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (st == S_RX && bit_cnt == 4'd0));

    p_stop_enters_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (st == S_IDLE));

    p_drive_on_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> !scl_lvl);

    p_release_on_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_lvl);

    p_silent_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !drive);

    p_page_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_push && buf_cnt == CW'(PAGE_BYTES)) |=> (buf_cnt == CW'(PAGE_BYTES)));
endmodule

bind eeprom_2w_slave ee2w_checks #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .bus_start(bus_start),
    .bus_stop(bus_stop), .drive(sda_pull_low), .prog_busy(prog_busy),
    .st(st), .bit_cnt(bit_cnt), .buf_push(buf_push), .buf_cnt(buf_cnt));

// File: tb/eeprom_2w_slave_tb.sv
module eeprom_2w_slave_tb;
    localparam int         PROG  = 400;
    localparam int         Q     = 8;
    localparam int         DEPTH = 256;
    localparam int         PAGE  = 16;
    localparam logic [6:0] DEV   = 7'h50;

    logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic drv, sda_bus;
    int   total = 0, bad = 0, cyc = 0, busy_until = 0;
    logic [7:0] ref_mem [DEPTH];
    int   ref_ptr = 0;
    int   pend_a [$];
    int   pend_d [$];
    logic drv_q = 1'b0;

    always #2 clk = ~clk;
    assign sda_bus = m_sda & ~drv;

    eeprom_2w_slave #(.DEV_ADDR(DEV), .MEM_DEPTH(DEPTH), .PAGE_BYTES(PAGE),
                      .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_low(drv));

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // every clock: silence during programming, drive changes only while SCL low
    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc < busy_until) check(drv == 1'b0, "R6 silent while busy", drv, 0);
            if (drv !== drv_q) check(m_scl == 1'b0, "R3 drive change with clock low", m_scl, 0);
        end
        drv_q = drv;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(2);
        pend_a.delete(); pend_d.delete();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1;
        if (pend_a.size() > 0) begin
            foreach (pend_a[i]) ref_mem[pend_a[i]] = 8'(pend_d[i]);
            busy_until = cyc + PROG + 6;
        end
        pend_a.delete(); pend_d.delete();
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(Q);
            m_scl = 1'b0; tick(2);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_bus;
            m_scl = 1'b0; tick(2);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    // write burst with model of the page buffer (last PAGE bytes kept)
    task automatic do_write(input int addr, input int n, input int base, input string tag);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R1 R4 write address ack", a, 1);
        send_byte(8'(addr), a);    check(a, "R7 pointer ack", a, 1);
        ref_ptr = addr;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'(base + i * 7);
            send_byte(d, a); check(a, tag, a, 1);
            pend_a.push_back(ref_ptr); pend_d.push_back(d);
            if (pend_a.size() > PAGE) begin
                void'(pend_a.pop_front()); void'(pend_d.pop_front());
            end
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end
        bus_stop();
    endtask

    task automatic read_body(input int n, input string tag);
        bit a;
        logic [7:0] b;
        send_byte({DEV, 1'b1}, a); check(a, "R4 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            check(b == ref_mem[ref_ptr], tag, b, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % DEPTH;
        end
        tick(4);
        check(drv == 1'b0, "R11 released after master nack", drv, 0);
        bus_stop();
    endtask

    task automatic read_random(input int addr, input int n, input string tag);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R4 address ack", a, 1);
        send_byte(8'(addr), a);    check(a, "R7 pointer ack", a, 1);
        ref_ptr = addr;
        bus_start();
        read_body(n, tag);
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        tick(5);
        check(drv == 1'b0, "R12 released in reset", drv, 0);
        rst_n = 1'b1;
        tick(5);
        check(drv == 1'b0, "R12 released after reset", drv, 0);

        // R12: array starts at zero; current read from pointer zero
        bus_start();
        ref_ptr = 0;
        read_body(2, "R12 zero memory at pointer 0");

        // R7: three bytes, then R6: address poll during programming
        do_write(8'h10, 3, 8'hA1, "R7 data ack");
        bus_start();
        send_byte({DEV, 1'b0}, a); check(!a, "R6 no ack while busy", a, 0);
        bus_stop();
        tick(PROG);
        read_random(8'h10, 3, "R10 read back");
        bus_start();
        read_body(2, "R10 current address continues");

        // R5: foreign address ignored until STOP
        bus_start();
        send_byte(8'hB4, a); check(!a, "R5 foreign address nack", a, 0);
        send_byte(8'h10, a); check(!a, "R5 later byte nack", a, 0);
        send_byte(8'hFF, a); check(!a, "R5 later byte nack", a, 0);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R2 R5 served after stop", a, 1);
        bus_stop();
        read_random(8'h10, 3, "R5 memory unchanged");

        // R8: 20-byte burst keeps the last 16
        do_write(8'h40, 20, 8'h30, "R8 burst data ack");
        tick(PROG + 10);
        read_random(8'h40, 20, "R8 last sixteen stored");

        // R9: pointer-only write starts no programming cycle
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R9 address ack", a, 1);
        send_byte(8'h44, a);       check(a, "R9 pointer ack", a, 1);
        ref_ptr = 8'h44;
        bus_stop();
        bus_start();
        read_body(1, "R9 no cycle after pointer-only write");

        // R9: repeated START discards buffered bytes
        bus_start();
        send_byte({DEV, 1'b0}, a); check(a, "R9 address ack", a, 1);
        send_byte(8'h80, a);       check(a, "R9 pointer ack", a, 1);
        send_byte(8'h11, a);       check(a, "R9 data ack", a, 1);
        send_byte(8'h22, a);       check(a, "R9 data ack", a, 1);
        ref_ptr = 8'h82;
        bus_start();
        read_body(1, "R10 read after repeated start");
        tick(PROG);
        read_random(8'h80, 2, "R9 discarded bytes absent");

        // R7: pointer wraps at the end of the array
        do_write(8'hFE, 4, 8'h90, "R7 wrap data ack");
        tick(PROG + 10);
        read_random(8'hFE, 4, "R7 wrap read back");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule